// File: doc/BRIEF.md
# Banked GPIO Controller with Pin Interrupts

This block is a 32-pin general-purpose I/O controller on a simple memory-mapped register port. The pins are grouped into four banks of eight. Each bank has its own 64-byte register window. Within a bank, software chooses per pin whether the pad drives the value held in an output latch or is used as an input. Software also reads the pad levels through a synchronizer.

Every pin can raise an interrupt. A pin is either edge-triggered, where a rising edge latches a sticky status bit, or level-sensitive, where the status is held while the pin stays high. Status bits are cleared by writing ones. Each bank keeps a mask, which is set and cleared through two separate write offsets. The unmasked status bits of all banks are ORed into a single interrupt line.

The bus has a valid strobe, a write enable, a byte address, and write data. Read data is returned combinationally in the same cycle as the request. A write takes effect at the next clock edge.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, the following values hold in every bank: direction, output latch, mode and status read 0, the mask reads 0xFF, `irq` is low, `pad_oe` is all ones and `pad_out` is all zeros.
- R2: The address is decoded as follows. Bits [7:6] select the bank, bits [5:2] select the register word, and bits [1:0] must be zero. Pin n is bit n&7 of bank n>>3, so pin 10 is bit 2 of the window at 0x40. A misaligned access reads zero and writes nothing.
- R3: The direction register is at offset 0x10 and the output latch at 0x14. Both can be read and written. A direction bit of 1 makes the pin an input. `pad_oe` is the inverse of the direction bit, and `pad_out` equals the latch bit when `pad_oe` is high and 0 otherwise.
- R4: Offset 0x18 returns the pad levels after a two-flop synchronizer. A pad change shows there once two clock edges have passed.
- R5: Offset 0x20 selects the mode per pin: 1 for level, 0 for edge. In edge mode, a rising edge of the synchronized pin sets the status bit. The bit stays set after the pin falls. Writing a one to the same bit at offset 0x04 clears it, and offset 0x04 reads the raw status.
- R6: In level mode, a synchronized high level sets the status bit. A clear written while the level is still high has no effect. Once the pin is low, the bit stays set until it is cleared.
- R7: Writing to offset 0x08 sets the mask bits that are written as one. Writing to offset 0x0C clears them. Offset 0x08 reads the mask, and offset 0x0C reads zero. Writing 0xFF to 0x08 masks the whole bank.
- R8: Offset 0x00 reads status AND NOT mask. `irq` is the OR of those bits across all banks.
- R9: Writes to the read-only offsets 0x00 and 0x18 change nothing. Unused offsets read zero. Only data bits [7:0] are stored, and read data bits [31:8] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The interrupt logic is tested with three input patterns.
- A held-high pin in edge mode shows that a single rising edge latches once, and that the latch clears while the pin is still high.
- The same held level in level mode must survive a clear and then persist after the pin falls. This separates level hold from edge latching.
- An unmasked single pin in bank 1, with every other bank masked, shows that `irq` and the masked view follow only that bit, and that the bank decode lands on pin 10.

Data patterns with different upper and lower bits, such as 0xA5 in the latch and 0x0F in direction, show that output gating follows the inverted direction bit by bit. Writes to read-only and unused offsets are followed by readbacks to confirm that nothing changed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
   localparam int WIN_BITS = 6;   // 64-byte window per bank

   typedef enum logic [3:0] {
      REG_MSTAT = 4'h0,
      REG_RSTAT = 4'h1,
      REG_MSET  = 4'h2,
      REG_MCLR  = 4'h3,
      REG_DIR   = 4'h4,
      REG_OUT   = 4'h5,
      REG_PIN   = 4'h6,
      REG_MODE  = 4'h8
   } reg_sel_e;
endpackage

// File: rtl/gpio_sync_chain.sv
module gpio_sync_chain #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[s] <= '0;
               else        stg[s] <= stg[s-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_reg_bank.sv
module gpio_reg_bank
   import gpio_bank_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         acc_wr,
   input  reg_sel_e     acc_off,
   input  logic [W-1:0] wr_data,
   input  logic [W-1:0] pin_lvl,
   output logic [W-1:0] rd_data,
   output logic [W-1:0] dir_q,
   output logic [W-1:0] out_q,
   output logic [W-1:0] pend
);
   logic [W-1:0] mask_q, mode_q, stat_q, prev_q;
   logic [W-1:0] set_v, clr_v;

   // level mode: high level sets; edge mode: rise of the synchronized pin sets
   assign set_v = (mode_q & pin_lvl) | (~mode_q & pin_lvl & ~prev_q);
   assign clr_v = (acc_wr && acc_off == REG_RSTAT) ? wr_data : '0;
   assign pend  = stat_q & ~mask_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         mode_q <= '0;
         mask_q <= '1;
         stat_q <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= pin_lvl;
         stat_q <= (stat_q & ~clr_v) | set_v;   // set wins over clear
         if (acc_wr) begin
            case (acc_off)
               REG_DIR:  dir_q  <= wr_data;
               REG_OUT:  out_q  <= wr_data;
               REG_MODE: mode_q <= wr_data;
               REG_MSET: mask_q <= mask_q | wr_data;
               REG_MCLR: mask_q <= mask_q & ~wr_data;
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      case (acc_off)
         REG_MSTAT: rd_data = pend;
         REG_RSTAT: rd_data = stat_q;
         REG_MSET:  rd_data = mask_q;
         REG_DIR:   rd_data = dir_q;
         REG_OUT:   rd_data = out_q;
         REG_PIN:   rd_data = pin_lvl;
         REG_MODE:  rd_data = mode_q;
         default:   rd_data = '0;
      endcase
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_off == REG_MSET) |=> ((mask_q & $past(wr_data)) == $past(wr_data))); // R7
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_off == REG_MCLR) |=> ((mask_q & $past(wr_data)) == '0)); // R7
   AST_STAT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_off == REG_RSTAT) |=> ((stat_q & $past(wr_data) & ~$past(set_v)) == '0)); // R5
   AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (|(mode_q & pin_lvl)) |=> ((stat_q & $past(mode_q & pin_lvl)) == $past(mode_q & pin_lvl))); // R6
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && acc_off == REG_DIR) |=> (dir_q == $past(wr_data))); // R3
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
   import gpio_bank_pkg::*;
#(
   parameter int NUM_BANKS   = 4,
   parameter int BANK_W      = 8,
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 8,
   parameter int SYNC_STAGES = 2,
   localparam int PINS       = NUM_BANKS * BANK_W,
   localparam int BANK_SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pad_oe,
   output logic              irq
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((1 << BANK_SEL_W) != NUM_BANKS || NUM_BANKS < 2) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (ADDR_W != WIN_BITS + BANK_SEL_W) begin : g_bad_addr
         $error("ADDR_W must equal window bits plus bank select bits");
      end
      if (BANK_W >= DATA_W) begin : g_bad_data
         $error("BANK_W must be narrower than DATA_W");
      end
   endgenerate

   logic [PINS-1:0]       pin_sync;
   logic                  acc_ok;
   logic [BANK_SEL_W-1:0] bank_idx;
   reg_sel_e              off_w;
   logic [BANK_W-1:0]     bank_rd   [NUM_BANKS];
   logic [NUM_BANKS-1:0]  bank_pend;
   logic [PINS-1:0]       dir_all, out_all;
   logic                  unused_wdata_hi;

   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:BANK_W];
   assign acc_ok   = bus_valid && (bus_addr[1:0] == 2'b00);
   assign bank_idx = bus_addr[ADDR_W-1:WIN_BITS];
   assign off_w    = reg_sel_e'(bus_addr[WIN_BITS-1:2]);

   gpio_sync_chain #(.W(PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pin_sync)
   );

   generate
      for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
         logic              wr_b;
         logic [BANK_W-1:0] pend_b;
         assign wr_b = acc_ok && bus_we && (bank_idx == BANK_SEL_W'(b));

         gpio_reg_bank #(.W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .acc_wr  (wr_b),
            .acc_off (off_w),
            .wr_data (bus_wdata[BANK_W-1:0]),
            .pin_lvl (pin_sync[b*BANK_W +: BANK_W]),
            .rd_data (bank_rd[b]),
            .dir_q   (dir_all[b*BANK_W +: BANK_W]),
            .out_q   (out_all[b*BANK_W +: BANK_W]),
            .pend    (pend_b)
         );
         assign bank_pend[b] = |pend_b;
      end
   endgenerate

   assign pad_oe    = ~dir_all;
   assign pad_out   = out_all & ~dir_all;
   assign irq       = |bank_pend;
   assign bus_rdata = (acc_ok && !bus_we) ? DATA_W'(bank_rd[bank_idx]) : '0;

   AST_PAD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_out & ~pad_oe) == '0)); // R3
   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_valid) |-> (bus_rdata == '0)); // R9
endmodule

// File: tb/sim_gpio_bank_ctrl.sv
module sim_gpio_bank_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_out, pad_oe;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   gpio_bank_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      bus_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      for (int b = 0; b < 4; b++) begin
         rd(8'(b*64 + 'h08), v); check("R1 mask", v, 32'hFF);
         rd(8'(b*64 + 'h10), v); check("R1 dir", v, 32'h0);
         rd(8'(b*64 + 'h04), v); check("R1 status", v, 32'h0);
      end
      rd(8'h54, v); check("R1 out", v, 32'h0);
      rd(8'h60, v); check("R1 mode", v, 32'h0);
      check("R1 irq", {31'b0, irq}, 32'h0);
      check("R1 pad_oe", pad_oe, 32'hFFFF_FFFF);
      check("R1 pad_out", pad_out, 32'h0);
   endtask

   task automatic t_dir_out();
      logic [31:0] v;
      wr(8'h94, 32'h0000_00A5);
      wr(8'h90, 32'h0000_000F);
      rd(8'h94, v); check("R3 out readback", v, 32'hA5);
      rd(8'h90, v); check("R3 dir readback", v, 32'h0F);
      check("R3 oe bank2", {24'b0, pad_oe[23:16]}, 32'hF0);
      check("R3 out bank2", {24'b0, pad_out[23:16]}, 32'hA0);
      check("R2 other banks untouched", {pad_oe[31:24], pad_oe[15:0]}, 24'hFFFFFF);
      wr(8'h95, 32'h0000_0011);   // misaligned: ignored
      rd(8'h94, v); check("R2 misaligned write ignored", v, 32'hA5);
      rd(8'h96, v); check("R2 misaligned read zero", v, 32'h0);
      wr(8'h94, 32'hFFFF_FF5A);
      rd(8'h94, v); check("R9 upper data bits dropped", v, 32'h5A);
   endtask

   task automatic t_input();
      logic [31:0] v;
      @(negedge clk); pad_in[31:24] = 8'h3C;
      @(negedge clk); @(negedge clk);
      #1 bus_valid = 1'b1; bus_addr = 8'hD8;
      #1 v = bus_rdata; bus_valid = 1'b0;
      check("R4 sync after two edges", v, 32'h3C);
      wr(8'hD8, 32'hFF);
      rd(8'hD8, v); check("R9 input view write ignored", v, 32'h3C);
      wr(8'hC8, 32'hFF);
   endtask

   task automatic t_edge();
      logic [31:0] v;
      @(negedge clk); pad_in[10] = 1'b1;
      idle(4);
      rd(8'h44, v); check("R5 edge sets pin10 status", v, 32'h04);
      rd(8'h40, v); check("R8 masked view while masked", v, 32'h0);
      check("R8 irq low while masked", {31'b0, irq}, 32'h0);
      wr(8'h4C, 32'h04);
      rd(8'h48, v); check("R7 unmask clears bit", v, 32'hFB);
      rd(8'h4C, v); check("R7 unmask offset reads zero", v, 32'h0);
      rd(8'h40, v); check("R8 masked view", v, 32'h04);
      check("R8 irq high", {31'b0, irq}, 32'h1);
      wr(8'h40, 32'hFF);
      rd(8'h44, v); check("R9 masked view write ignored", v, 32'h04);
      wr(8'h44, 32'h04);
      rd(8'h44, v); check("R5 clear while pin high", v, 32'h0);
      check("R8 irq low after clear", {31'b0, irq}, 32'h0);
      @(negedge clk); pad_in[10] = 1'b0;
      idle(4);
      rd(8'h44, v); check("R5 falling edge no set", v, 32'h0);
      wr(8'h48, 32'hFF);
      rd(8'h48, v); check("R7 mask set all", v, 32'hFF);
   endtask

   task automatic t_level();
      logic [31:0] v;
      wr(8'h20, 32'h01);
      rd(8'h20, v); check("R5 mode readback", v, 32'h01);
      @(negedge clk); pad_in[0] = 1'b1;
      idle(4);
      rd(8'h04, v); check("R6 level sets", v, 32'h01);
      wr(8'h04, 32'h01);
      rd(8'h04, v); check("R6 clear blocked while high", v, 32'h01);
      @(negedge clk); pad_in[0] = 1'b0;
      idle(4);
      rd(8'h04, v); check("R6 sticky after low", v, 32'h01);
      wr(8'h04, 32'h01);
      rd(8'h04, v); check("R6 clear after low", v, 32'h0);
      rd(8'h1C, v); check("R9 unused offset zero", v, 32'h0);
      rd(8'h3C, v); check("R9 unused offset zero high", v, 32'h0);
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_dir_out();
      t_input();
      t_edge();
      t_level();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule